// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a countdown watchdog that software programs through a byte-wide register port. The countdown unit is either one second or one minute. A parameter gives the number of clock cycles in a second, and a minute is built from sixty second ticks. Software arms the watchdog by writing a non-zero timeout. It keeps the system alive by writing the timeout again before the count runs out. It disarms the watchdog by writing a timeout of zero.

When the count reaches zero, the block sets a sticky expiry flag and stops. It then drives a reset pulse of fixed length on each reset route that the configuration enables: a keyboard-controller reset and a power-good reset. With both routes disabled (test mode), the count still runs and the flag is still set, but no reset leaves the block. The counter is 16 bits wide by default. A build parameter narrows it to 8 bits, and the 8-bit build has no high timeout byte.

The register decode is fixed: 0x71 control, 0x72 configuration, 0x73 timeout low byte, 0x74 timeout high byte. Reads are combinational from `reg_addr`. Reading a timeout byte returns the live count.

Top module: `sm_watchdog`

## Requirements
- R1: After reset, every register reads 0x00, the count is 0, the timer is stopped and both reset outputs are low.
- R2: A write to 0x73 loads the count with {staged high byte, written byte}. A non-zero value starts the timer and restarts the time base. Reads of 0x73 and 0x74 return the low and high bytes of the live count.
- R3: With configuration bit 7 set, the count drops by one every CLKS_PER_SEC cycles. Expiry happens exactly N*CLKS_PER_SEC cycles after the write of a value N.
- R4: With configuration bit 7 clear, the count drops by one every 60*CLKS_PER_SEC cycles.
- R5: Loading a value of zero stops the timer. No expiry and no reset pulse follow.
- R6: Rewriting the timeout while the timer runs reloads the count and restarts the time base, so expiry moves to N units after the latest write.
- R7: At expiry, kbd_reset_o is high for exactly PULSE_LEN cycles if configuration bit 6 was set, and pwrgood_reset_o likewise if bit 4 was set. A disabled route stays low.
- R8: With bits 6 and 4 both clear, expiry still sets the flag but neither reset output rises.
- R9: Expiry sets control bit 0. The bit stays set until a write of 0x71 with bit 0 = 1 clears it. Writing 0 to that bit leaves it set.
- R10: After expiry the count stays 0 and no further pulse occurs until the timeout is rewritten.
- R11: All eight configuration bits read back as written. The routing field in bits 3:0 has no effect on the reset outputs.
- R12: In the 8-bit build (WIDE_COUNT=0), writes to 0x74 are ignored, 0x74 reads 0x00, and a write to 0x73 loads only the written byte.
- R13: A write to 0x74 only stages the high byte. The live count does not change until 0x73 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Combinational read data for reg_addr |
| kbd_reset_o | output | 1 | Keyboard-controller reset pulse on expiry |
| pwrgood_reset_o | output | 1 | Power-good reset pulse on expiry |

## Verification
The bench targets the exact expiry cycle in both time bases. A prescaler that is off by one, or a minute counter that wraps at the wrong count, moves the pulse by a cycle or by a whole second. It checks that a keepalive write restarts the prescaler. A design that only reloads the count would fire up to one unit early. It also checks that staging the high byte does not disturb the live count, and that a zero write fully disarms the timer rather than expiring on the next tick. Other targets are the sticky flag's write-one-to-clear rule, the independent reset routes, and test mode. A design that gated the flag on the enables, or that ignored the enables, would show it at the pins.

// File: rtl/smwd_pkg.sv
package smwd_pkg;

    localparam logic [7:0] ADDR_CTRL = 8'h71;
    localparam logic [7:0] ADDR_CFG  = 8'h72;
    localparam logic [7:0] ADDR_TLO  = 8'h73;
    localparam logic [7:0] ADDR_THI  = 8'h74;

    localparam int SECS_PER_MIN = 60;

    typedef struct packed {
        logic       sec_base;
        logic       kbd_en;
        logic       spare;
        logic       pwr_en;
        logic [3:0] irq_route;
    } cfg_t;

    function automatic logic [7:0] status_byte(input logic flag);
        return {7'b0, flag};
    endfunction

endpackage

// File: rtl/smwd_regs.sv
module smwd_regs
    import smwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             expire_stb,
    output logic [7:0]       rdata,
    output logic             load_stb,
    output logic [CNT_W-1:0] load_val,
    output logic             sec_base,
    output logic             kbd_en,
    output logic             pwr_en,
    output logic             status
);

    cfg_t        cfg_q;
    logic [15:0] cnt_ext;

    assign cnt_ext  = 16'(cnt);
    assign load_stb = wr_en && (addr == ADDR_TLO);
    assign sec_base = cfg_q.sec_base;
    assign kbd_en   = cfg_q.kbd_en;
    assign pwr_en   = cfg_q.pwr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && addr == ADDR_CFG) begin
            cfg_q <= cfg_t'(wdata);
        end
    end

    // expiry wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (expire_stb) begin
            status <= 1'b1;
        end else if (wr_en && addr == ADDR_CTRL && wdata[0]) begin
            status <= 1'b0;
        end
    end

    generate
        if (CNT_W > 8) begin : g_wide
            logic [CNT_W-9:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_q <= '0;
                end else if (wr_en && addr == ADDR_THI) begin
                    hi_q <= wdata[CNT_W-9:0];
                end
            end
            assign load_val = {hi_q, wdata};
        end else begin : g_narrow
            assign load_val = CNT_W'(wdata);
        end
    endgenerate

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = status_byte(status);
            ADDR_CFG:  rdata = cfg_q;
            ADDR_TLO:  rdata = cnt_ext[7:0];
            ADDR_THI:  rdata = cnt_ext[15:8];
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/smwd_timebase.sv
module smwd_timebase
    import smwd_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sec_base,
    output logic unit_tick
);

    localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam int MW = $clog2(SECS_PER_MIN);

    logic [PW-1:0] presc_q;
    logic [MW-1:0] min_q;
    logic          sec_tick;
    logic          min_wrap;

    assign sec_tick  = (presc_q == PW'(CLKS_PER_SEC - 1));
    assign min_wrap  = (min_q == MW'(SECS_PER_MIN - 1));
    assign unit_tick = sec_tick && (sec_base || min_wrap);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            presc_q <= '0;
            min_q   <= '0;
        end else begin
            presc_q <= sec_tick ? '0 : presc_q + 1'b1;
            if (sec_tick) begin
                min_q <= min_wrap ? '0 : min_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smwd_counter.sv
module smwd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             unit_tick,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire_stb
);

    assign expire_stb = running && unit_tick && !load_stb && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load_stb) begin
            cnt     <= load_val;
            running <= (load_val != '0);
        end else if (running && unit_tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                running <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smwd_pulse.sv
module smwd_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic kbd_en,
    input  logic pwr_en,
    output logic kbd_o,
    output logic pwr_o
);

    localparam int LW = $clog2(PULSE_LEN + 1);

    logic [LW-1:0] len_q;
    logic          kbd_q;
    logic          pwr_q;
    logic          active;

    assign active = (len_q != '0);
    assign kbd_o  = active && kbd_q;
    assign pwr_o  = active && pwr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            kbd_q <= 1'b0;
            pwr_q <= 1'b0;
        end else if (fire) begin
            len_q <= LW'(PULSE_LEN);
            kbd_q <= kbd_en;
            pwr_q <= pwr_en;
        end else if (active) begin
            len_q <= len_q - 1'b1;
        end
    end

endmodule

// File: rtl/sm_watchdog.sv
module sm_watchdog
    import smwd_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768,
    parameter int PULSE_LEN    = 16,
    parameter bit WIDE_COUNT   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wr_data,
    output logic [7:0] reg_rd_data,
    output logic       kbd_reset_o,
    output logic       pwrgood_reset_o
);

    localparam int CNT_W = WIDE_COUNT ? 16 : 8;

    logic             load_stb;
    logic [CNT_W-1:0] load_val;
    logic             sec_base;
    logic             kbd_en;
    logic             pwr_en;
    logic             status;
    logic             unit_tick;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             expire_stb;

    smwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wr_data),
        .cnt        (cnt),
        .expire_stb (expire_stb),
        .rdata      (reg_rd_data),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .sec_base   (sec_base),
        .kbd_en     (kbd_en),
        .pwr_en     (pwr_en),
        .status     (status)
    );

    smwd_timebase #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .restart   (load_stb),
        .sec_base  (sec_base),
        .unit_tick (unit_tick)
    );

    smwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .unit_tick  (unit_tick),
        .cnt        (cnt),
        .running    (running),
        .expire_stb (expire_stb)
    );

    smwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (expire_stb),
        .kbd_en (kbd_en),
        .pwr_en (pwr_en),
        .kbd_o  (kbd_reset_o),
        .pwr_o  (pwrgood_reset_o)
    );

endmodule

// File: rtl/smwd_checker.sv
module smwd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cnt,
    input logic             running,
    input logic             status,
    input logic             kbd_en,
    input logic             pwr_en,
    input logic             kbd_o,
    input logic             pwr_o
);

    // R5: a zero load disarms the timer
    p_zero_stops_r5: assert property (@(posedge clk) disable iff (rst)
        (load_stb && load_val == '0) |=> !running);

    // R3: without a load the count never moves by more than one step down
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        !load_stb |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) - 1'b1)));

    // R10: a stopped timer holds its count until reloaded
    p_hold_stopped_r10: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_stb) |=> $stable(cnt));

    // R9: a reset pulse never starts without the expiry flag
    p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(kbd_o) || $rose(pwr_o)) |-> status);

    // R7: each route only fires when its enable was set
    p_kbd_route_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(kbd_o) |-> $past(kbd_en));

    p_pwr_route_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_o) |-> $past(pwr_en));

endmodule

bind sm_watchdog smwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .load_val (load_val),
    .cnt      (cnt),
    .running  (running),
    .status   (status),
    .kbd_en   (kbd_en),
    .pwr_en   (pwr_en),
    .kbd_o    (kbd_reset_o),
    .pwr_o    (pwrgood_reset_o)
);

// File: tb/tb_sm_watchdog.sv
`timescale 1ns/1ps
module tb_sm_watchdog;

    localparam int CPS  = 16;
    localparam int PLEN = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0;
    logic       wr8 = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, rdata8;
    logic       kbd, pwr, kbd8, pwr8;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sm_watchdog #(.CLKS_PER_SEC(CPS), .PULSE_LEN(PLEN), .WIDE_COUNT(1'b1)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wr_data(wdata), .reg_rd_data(rdata),
        .kbd_reset_o(kbd), .pwrgood_reset_o(pwr));

    sm_watchdog #(.CLKS_PER_SEC(CPS), .PULSE_LEN(PLEN), .WIDE_COUNT(1'b0)) dut8 (
        .clk(clk), .rst(rst), .reg_wr_en(wr8), .reg_addr(addr),
        .reg_wr_data(wdata), .reg_rd_data(rdata8),
        .kbd_reset_o(kbd8), .pwrgood_reset_o(pwr8));

    typedef struct packed {
        logic       is_wr;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h72, 8'h55, 8'd11},  // R11 minute base, both routes, route field 5
        '{1'b0, 8'h72, 8'h55, 8'd11},  // R11 readback
        '{1'b1, 8'h74, 8'h01, 8'd13},  // R13 stage high byte
        '{1'b0, 8'h74, 8'h00, 8'd13},  // R13 live count untouched
        '{1'b0, 8'h73, 8'h00, 8'd13},
        '{1'b1, 8'h73, 8'h2C, 8'd2},   // R2 load 0x012C
        '{1'b0, 8'h73, 8'h2C, 8'd2},
        '{1'b0, 8'h74, 8'h01, 8'd2},
        '{1'b1, 8'h74, 8'h00, 8'd13},  // R13 stage zero
        '{1'b0, 8'h74, 8'h01, 8'd13},
        '{1'b1, 8'h73, 8'h00, 8'd5},   // R5 zero load
        '{1'b0, 8'h73, 8'h00, 8'd5},
        '{1'b0, 8'h71, 8'h00, 8'd9}    // R9 flag still clear
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d, input bit narrow);
        @(negedge clk);
        addr = a; wdata = d;
        if (narrow) wr8 = 1'b1; else wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wr8 = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] v, input bit narrow);
        addr = a;
        #1;
        v = narrow ? rdata8 : rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seen;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rreg(8'h71, v, 0); check("R1 ctrl", v, 0);
        rreg(8'h72, v, 0); check("R1 cfg", v, 0);
        rreg(8'h73, v, 0); check("R1 lo", v, 0);
        rreg(8'h74, v, 0); check("R1 hi", v, 0);
        check("R1 outputs", {kbd, pwr}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                wreg(VECS[i].a, VECS[i].d, 0);
            end else begin
                rreg(VECS[i].a, v, 0);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].d);
            end
        end

        // R3, R7, R11: second base, keyboard route only, route field nonzero
        wreg(8'h72, 8'hC3, 0);
        wreg(8'h74, 8'h00, 0);
        wreg(8'h73, 8'h03, 0);
        idle(16); rreg(8'h73, v, 0); check("R3 one step", v, 2);
        idle(31); rreg(8'h73, v, 0); check("R3 before expiry", v, 1);
        check("R3 no early pulse", kbd, 0);
        idle(1);
        check("R7 kbd high", kbd, 1);
        check("R7 pwr disabled", pwr, 0);
        rreg(8'h71, v, 0); check("R9 flag set", v, 1);
        idle(PLEN - 1); check("R7 kbd last cycle", kbd, 1);
        idle(1); check("R7 kbd ends", kbd, 0);

        // R9 sticky, write one to clear
        wreg(8'h71, 8'h00, 0); rreg(8'h71, v, 0); check("R9 write zero keeps", v, 1);
        wreg(8'h71, 8'h01, 0); rreg(8'h71, v, 0); check("R9 write one clears", v, 0);

        // R10 stays stopped
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            idle(1);
            if (kbd || pwr) seen++;
        end
        check("R10 no repeat pulse", seen, 0);
        rreg(8'h73, v, 0); check("R10 count held", v, 0);

        // R4 minute base, power-good route only
        wreg(8'h72, 8'h10, 0);
        wreg(8'h73, 8'h01, 0);
        idle(959);
        rreg(8'h73, v, 0); check("R4 before minute", v, 1);
        check("R4 no early pulse", pwr, 0);
        idle(1);
        check("R4 pwr at minute", pwr, 1);
        check("R7 kbd disabled", kbd, 0);
        wreg(8'h71, 8'h01, 0);
        idle(PLEN);

        // R6 keepalive restarts count and prescaler
        wreg(8'h72, 8'hC0, 0);
        wreg(8'h73, 8'h03, 0);
        idle(40);
        wreg(8'h73, 8'h03, 0);
        seen = 0;
        for (int i = 0; i < 47; i++) begin
            idle(1);
            if (kbd) seen++;
        end
        check("R6 no pulse before reload deadline", seen, 0);
        idle(1);
        check("R6 pulse at reload deadline", kbd, 1);
        wreg(8'h71, 8'h01, 0);
        idle(PLEN);

        // R8 test mode
        wreg(8'h72, 8'h8F, 0);
        wreg(8'h73, 8'h01, 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            idle(1);
            if (kbd || pwr) seen++;
        end
        check("R8 no reset in test mode", seen, 0);
        rreg(8'h71, v, 0); check("R8 flag still set", v, 1);
        wreg(8'h71, 8'h01, 0);

        // R5 zero write disarms a running timer
        wreg(8'h72, 8'hD0, 0);
        wreg(8'h73, 8'h05, 0);
        wreg(8'h73, 8'h00, 0);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            idle(1);
            if (kbd || pwr) seen++;
        end
        check("R5 no pulse after zero", seen, 0);
        rreg(8'h71, v, 0); check("R5 flag clear", v, 0);

        // R12 narrow build
        wreg(8'h74, 8'h01, 1);
        wreg(8'h73, 8'h02, 1);
        rreg(8'h74, v, 1); check("R12 no high byte", v, 0);
        rreg(8'h73, v, 1); check("R12 low only load", v, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule